// File: doc/BRIEF.md
# Link Energy Loss Qualifier

This block turns a raw, noisy energy-present bit from a PHY receiver into a qualified cable status. A single zero reading is not trusted: the block watches the raw bit only at sample strobes and declares the line dead only after a run of consecutive zero readings. That run must complete inside one qualification window, nominally one second of clock cycles. A single reading of one cancels the run and restores the energy-present status at once. The status means nothing unless auto-negotiation is on. While it is off, the block holds its run state cleared and drives its valid output low.

Integration is simple. Tie `sampleTick` to the strobe that marks each read of the raw bit. Set `WINDOW_CYCLES` to the number of clock cycles in one second, or to a small value for simulation. Use `noEnergy` as the unplugged indication and `energyPresent` as the plugged indication, both qualified by `statusValid`.

Top module: `energy_loss_qualifier`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `energyPresent`, `noEnergy` and `statusValid` are all low.
- R2: `statusValid` equals the value `anEnable` had at the previous clock edge. Whenever `statusValid` is low, both `energyPresent` and `noEnergy` are low.
- R3: `noEnergy` rises only at the edge where `sampleTick` is high with `rawEnergy` low, and only once that sample completes a run of `LOSS_COUNT` (default 3) consecutive zero samples.
- R4: A run is timed from the edge of its first zero sample. A zero sample taken k clock edges later continues the run only if k < `WINDOW_CYCLES`. Otherwise that sample starts a new run as its first sample.
- R5: A sample with `rawEnergy` high, taken while auto-negotiation is enabled, clears the run and the loss flag. `energyPresent` is high on the next cycle.
- R6: When `sampleTick` is low, `rawEnergy` has no effect on the run or on the outputs.
- R7: Sampling `anEnable` low clears the run and `noEnergy`. A later zero sample then starts a fresh run from count one.
- R8: `energyPresent` is high exactly when `statusValid` is high and `noEnergy` is low.
- R9: Once `noEnergy` is high, further zero samples keep it high, whatever their spacing in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rawEnergy | input | 1 | Unqualified energy-present bit from the receiver |
| anEnable | input | 1 | Auto-negotiation enabled |
| sampleTick | input | 1 | One-cycle strobe marking a read of `rawEnergy` |
| energyPresent | output | 1 | Qualified energy on line (cable plugged) |
| noEnergy | output | 1 | Qualified energy loss (cable unplugged) |
| statusValid | output | 1 | Status outputs are meaningful |

## Verification
The assertions assume that `rawEnergy` and `anEnable` are only of interest at clock edges. They also assume that `sampleTick` is an ordinary one-cycle strobe, which may even be high on consecutive cycles. The properties therefore tie every rise of the loss flag to a zero sample taken with auto-negotiation on, and never to the spacing of strobes. The stimulus changes inputs only on the falling clock edge. Random phases mostly hold auto-negotiation on and spread strobes sparsely, so that zero runs both finish and miss the shortened window. Short disabled stretches are mixed in to exercise the clearing path.

// File: rtl/elq_pkg.sv
package elq_pkg;

  typedef struct packed {
    logic clearAll;
    logic clearRun;
    logic startRun;
    logic stepRun;
    logic setLost;
    logic clearLost;
  } qualStrobe_t;

endpackage

// File: rtl/elq_ctrl.sv
module elq_ctrl
  import elq_pkg::*;
#(
  parameter int LOSS_COUNT = 3,
  localparam int CNT_W = $clog2(LOSS_COUNT + 1)
) (
  input  logic             anEnable,
  input  logic             sampleTick,
  input  logic             rawEnergy,
  input  logic [CNT_W-1:0] zeroCnt,
  input  logic             windowOpen,
  input  logic             lost,
  output qualStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOSS_COUNT - 1);

  logic runIdle;
  logic runFinal;

  assign runIdle  = (zeroCnt == '0) || !windowOpen;
  assign runFinal = (zeroCnt == LAST_CNT);

  always_comb begin
    strobe = '0;
    if (!anEnable) begin
      strobe.clearAll = 1'b1;
    end else if (sampleTick) begin
      if (rawEnergy) begin
        strobe.clearRun  = 1'b1;
        strobe.clearLost = 1'b1;
      end else if (!lost) begin
        if (runIdle) begin
          strobe.startRun = 1'b1;
          strobe.setLost  = (LOSS_COUNT == 1);
        end else begin
          strobe.stepRun = 1'b1;
          strobe.setLost = runFinal;
        end
      end
    end
  end

endmodule

// File: rtl/elq_datapath.sv
module elq_datapath
  import elq_pkg::*;
#(
  parameter int WINDOW_CYCLES = 125_000_000,
  parameter int LOSS_COUNT    = 3,
  localparam int CNT_W = $clog2(LOSS_COUNT + 1),
  localparam int AGE_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             anEnable,
  input  qualStrobe_t      strobe,
  output logic [CNT_W-1:0] zeroCnt,
  output logic             windowOpen,
  output logic             lost,
  output logic             valid
);

  localparam logic [AGE_W-1:0] AGE_LIMIT = AGE_W'(WINDOW_CYCLES);

  logic [AGE_W-1:0] runAge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zeroCnt <= '0;
      runAge  <= '0;
      lost    <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= anEnable;
      if (strobe.clearAll) begin
        zeroCnt <= '0;
        runAge  <= '0;
        lost    <= 1'b0;
      end else begin
        if (strobe.clearRun)       zeroCnt <= '0;
        else if (strobe.startRun)  zeroCnt <= CNT_W'(1);
        else if (strobe.stepRun)   zeroCnt <= zeroCnt + CNT_W'(1);

        if (strobe.startRun)         runAge <= AGE_W'(1);
        else if (strobe.clearRun)    runAge <= '0;
        else if (runAge < AGE_LIMIT) runAge <= runAge + AGE_W'(1);

        if (strobe.clearLost)     lost <= 1'b0;
        else if (strobe.setLost)  lost <= 1'b1;
      end
    end
  end

  assign windowOpen = (runAge < AGE_LIMIT);

endmodule

// File: rtl/energy_loss_qualifier.sv
module energy_loss_qualifier
  import elq_pkg::*;
#(
  parameter int WINDOW_CYCLES = 125_000_000,
  parameter int LOSS_COUNT    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawEnergy,
  input  logic anEnable,
  input  logic sampleTick,
  output logic energyPresent,
  output logic noEnergy,
  output logic statusValid
);

  localparam int CNT_W = $clog2(LOSS_COUNT + 1);

  qualStrobe_t      strobe;
  logic [CNT_W-1:0] zeroCnt;
  logic             windowOpen;
  logic             lost;
  logic             valid;

  elq_ctrl #(.LOSS_COUNT(LOSS_COUNT)) u_ctrl (
    .anEnable   (anEnable),
    .sampleTick (sampleTick),
    .rawEnergy  (rawEnergy),
    .zeroCnt    (zeroCnt),
    .windowOpen (windowOpen),
    .lost       (lost),
    .strobe     (strobe)
  );

  elq_datapath #(.WINDOW_CYCLES(WINDOW_CYCLES), .LOSS_COUNT(LOSS_COUNT)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .anEnable   (anEnable),
    .strobe     (strobe),
    .zeroCnt    (zeroCnt),
    .windowOpen (windowOpen),
    .lost       (lost),
    .valid      (valid)
  );

  assign statusValid   = valid;
  assign noEnergy      = lost;
  assign energyPresent = valid & ~lost;

endmodule

// File: rtl/elq_checker.sv
module elq_checker (
  input logic clk,
  input logic rst_n,
  input logic rawEnergy,
  input logic anEnable,
  input logic sampleTick,
  input logic energyPresent,
  input logic noEnergy,
  input logic statusValid
);

  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    anEnable |=> statusValid);

  p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !anEnable |=> !statusValid);

  p_quiet_when_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !statusValid |-> (!energyPresent && !noEnergy));

  p_loss_from_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noEnergy) |-> $past(sampleTick && !rawEnergy && anEnable));

  p_one_restores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (anEnable && sampleTick && rawEnergy) |=> energyPresent);

  p_no_tick_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (anEnable && !sampleTick) |=> $stable(noEnergy));

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !anEnable |=> !noEnergy);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(energyPresent && noEnergy));

  p_loss_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (noEnergy && anEnable && !(sampleTick && rawEnergy)) |=> noEnergy);

endmodule

bind energy_loss_qualifier elq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rawEnergy     (rawEnergy),
  .anEnable      (anEnable),
  .sampleTick    (sampleTick),
  .energyPresent (energyPresent),
  .noEnergy      (noEnergy),
  .statusValid   (statusValid)
);

// File: tb/tb_energy_loss_qualifier.sv
`timescale 1ns/1ps
module tb_energy_loss_qualifier;

  localparam int WIN  = 20;
  localparam int LOSS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rawEnergy = 1'b1;
  logic anEnable = 1'b0;
  logic sampleTick = 1'b0;
  logic energyPresent, noEnergy, statusValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int  mCnt = 0;
  int  mStart = 0;
  int  edgeNo = 0;
  bit  mLost = 1'b0;
  bit  mValid = 1'b0;

  always #4 clk = ~clk;

  energy_loss_qualifier #(.WINDOW_CYCLES(WIN), .LOSS_COUNT(LOSS)) dut (
    .clk(clk), .rst_n(rst_n), .rawEnergy(rawEnergy), .anEnable(anEnable),
    .sampleTick(sampleTick), .energyPresent(energyPresent),
    .noEnergy(noEnergy), .statusValid(statusValid)
  );

  function automatic bit expPresent();
    return mValid && !mLost;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (edge %0d)", req, what, act, exp, edgeNo);
    end
  endtask

  task automatic checkAll(string req);
    check(req, statusValid, mValid, "statusValid");
    check(req, noEnergy, mLost, "noEnergy");
    check(req, energyPresent, expPresent(), "energyPresent");
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit an, bit tick, bit raw, string req);
    anEnable = an; sampleTick = tick; rawEnergy = raw;
    @(posedge clk);
    edgeNo++;
    if (!an) begin
      mCnt = 0; mLost = 1'b0;
    end else if (tick) begin
      if (raw) begin
        mCnt = 0; mLost = 1'b0;
      end else if (!mLost) begin
        if (mCnt == 0 || (edgeNo - mStart) >= WIN) begin
          mCnt = 1; mStart = edgeNo;
        end else begin
          mCnt++;
        end
        if (mCnt == LOSS) mLost = 1'b1;
      end
    end
    mValid = an;
    @(negedge clk);
    checkAll(req);
  endtask

  task automatic idle(int n, bit an, bit raw, string req);
    for (int i = 0; i < n; i++) step(an, 1'b0, raw, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    rst_n = 1'b0; anEnable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1");
    rst_n = 1'b1;
    mValid = 1'b0; mLost = 1'b0; mCnt = 0;
    checkAll("R1");

    // R2: valid follows AN
    step(1, 0, 1, "R2");
    step(1, 1, 1, "R2");
    // R3: three back-to-back zeros
    step(1, 1, 0, "R3");
    step(1, 1, 0, "R3");
    check("R3", noEnergy, 1'b0, "noEnergy before third zero");
    step(1, 1, 0, "R3");
    check("R3", noEnergy, 1'b1, "noEnergy after third zero");
    // R9: further spaced zeros keep loss
    idle(WIN + 5, 1, 0, "R9");
    step(1, 1, 0, "R9");
    check("R9", noEnergy, 1'b1, "loss held");
    // R6: raw toggles without tick
    idle(3, 1, 1, "R6");
    check("R6", noEnergy, 1'b1, "raw without tick ignored");
    // R5: one sample restores
    step(1, 1, 1, "R5");
    check("R5", energyPresent, 1'b1, "restored");

    // R4: third zero at exactly WIN edges after first -> new run
    step(1, 1, 0, "R4");
    idle(9, 1, 0, "R4");
    step(1, 1, 0, "R4");   // 10 edges after first
    idle(9, 1, 0, "R4");
    step(1, 1, 0, "R4");   // 20 edges: out of window
    check("R4", noEnergy, 1'b0, "window expired");
    // continue this new run: zeros at +1 and +19
    step(1, 1, 0, "R4");
    idle(17, 1, 0, "R4");
    step(1, 1, 0, "R4");   // 19 edges after run start
    check("R4", noEnergy, 1'b1, "third zero inside window");

    // R7: disable clears, then fresh run
    step(0, 1, 0, "R7");
    check("R7", noEnergy, 1'b0, "cleared by AN off");
    check("R2", statusValid, 1'b0, "invalid when AN off");
    step(1, 1, 0, "R7");
    step(1, 1, 0, "R7");
    check("R7", noEnergy, 1'b0, "fresh run count two");
    step(1, 1, 0, "R7");
    check("R7", noEnergy, 1'b1, "fresh run count three");
    step(1, 1, 1, "R8");
    check("R8", energyPresent, 1'b1, "present when valid and no loss");

    // random phase, R3 R4 R5 R8
    for (int i = 0; i < 4000; i++) begin
      bit an, tick, raw;
      an   = ($urandom_range(0, 49) != 0);
      tick = ($urandom_range(0, 3) == 0);
      raw  = ($urandom_range(0, 2) == 0);
      step(an, tick, raw, "R8");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule